// File: doc/BRIEF.md
# Per-Sub-Image Gamma Curve Converter

This block sits in a sensor channel after the input capture stage and maps each 12-bit sensor sample to a stored pixel value through a lookup curve. A sensor multiplexer can merge several sensors into one tall frame by sending their images one after another as extra lines. The converter counts lines from the start of each frame and moves through up to four regions at software-programmed line heights. It applies a separate curve to each region, so every stacked sub-image gets its own conversion.

The output is either a narrow 8-bit pixel, zero-extended on a 16-bit bus, or a wide 16-bit pixel. In wide mode a bypass control passes the raw sample through, left-justified. The result appears one clock after the input sample. Curves are loaded through a plain write port into a shadow bank for each region. The shadow bank becomes active at the next frame start, so a table rewritten during active video never tears a frame.

The input stream has a frame-valid level and a line-valid level. Line-valid is expected low in the cycle where frame-valid rises. Each update of a region replaces its whole table.

Top module: `subimg_gamma`

## Requirements
- R1: `out_lv` and `out_fv` equal `in_lv` and `in_fv` one clock earlier, and the converted value of a sample accepted at a rising edge is on `out_pix` after that same edge.
- R2: The curve entry for a sample is addressed by `in_pix[11:4]` (the upper 8 bits), so each region holds 256 entries of 16 bits.
- R3: A frame start (`in_fv` high where it was low one clock before) resets the line count and the region to 0, and the next line uses region 0.
- R4: When `fmt_wide` is 0, `out_pix` is `{8'h00, entry[7:0]}` and `bypass` has no effect.
- R5: Region r holds `sub_height[r*14 +: 14]` lines. When the line that completes that count ends (`in_lv` falls while `in_fv` is high), the region steps to r+1. Region 3 never steps, and a region with height 0 never steps.
- R6: A write with `wr_en` stores `wr_data` at entry `wr_addr` of region `wr_region`'s shadow bank and is not seen until the next frame start. At that frame start every region written since the previous one swaps its banks; other regions keep theirs. A write in the frame-start cycle counts as before that frame.
- R7: `out_pix` is 0 whenever `out_lv` is 0.
- R8: When `fmt_wide` is 1, `out_pix` is the full 16-bit entry if `bypass` is 0, and `{in_pix, 4'b0000}` if `bypass` is 1.
- R9: After reset, `out_lv`, `out_fv`, `out_pix` and `out_region` are all 0.
- R10: `out_region` shows, with each output sample, the region whose curve produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pix | input | 12 | Sensor sample |
| in_lv | input | 1 | Line valid |
| in_fv | input | 1 | Frame valid |
| sub_height | input | 56 | Four 14-bit region heights in lines, region 0 in the low bits |
| fmt_wide | input | 1 | 1 selects 16-bit output, 0 selects 8-bit output |
| bypass | input | 1 | Raw pass-through in wide mode |
| wr_en | input | 1 | Curve table write strobe |
| wr_region | input | 2 | Region whose table is written |
| wr_addr | input | 8 | Table entry index |
| wr_data | input | 16 | Table entry value |
| out_pix | output | 16 | Converted pixel |
| out_lv | output | 1 | Delayed line valid |
| out_fv | output | 1 | Delayed frame valid |
| out_region | output | 2 | Region of the output sample |

## Verification
The bench goes after region boundaries at exact line counts. A design off by one there would apply the next curve one line early or late. The bench also runs a zero-height region, which must hold its region instead of skipping it, and a tall frame, which must pin to the last region instead of wrapping to region 0. It restarts a frame halfway through the stack, rewrites a table during active video, and then checks that the old curve stays in use until the next frame start while an unwritten region keeps its bank. A single shared bank would change values in mid-frame. A swap on every frame start would turn untouched regions to stale tables. The format tests set bypass in narrow mode, where it must not leak, and check that blanking cycles output zero.

// File: rtl/sg_pkg.sv
package sg_pkg;

   // output pixel format selected by the wide/narrow control
   typedef enum logic {
      FMT_NARROW = 1'b0,
      FMT_WIDE   = 1'b1
   } fmt_e;

   // width of a narrow output pixel
   localparam int unsigned NARROW_W = 8;

endpackage

// File: rtl/sg_region_track.sv
module sg_region_track #(
   parameter int unsigned NREG   = 4,
   parameter int unsigned LINE_W = 14,
   localparam int unsigned RW    = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_lv,
   input  logic                   in_fv,
   input  logic [NREG*LINE_W-1:0] sub_height,
   output logic [RW-1:0]          region,
   output logic                   frame_start
);

   logic              fv_q;
   logic              lv_q;
   logic [LINE_W-1:0] line_q;
   logic [RW-1:0]     region_q;
   logic              line_end;
   logic [LINE_W-1:0] height_cur;
   logic [LINE_W-1:0] line_inc;
   logic              at_last;

   assign frame_start = in_fv & ~fv_q;
   assign line_end    = in_fv & lv_q & ~in_lv;
   assign height_cur  = sub_height[int'(region_q)*LINE_W +: LINE_W];
   assign line_inc    = line_q + LINE_W'(1);
   assign at_last     = (region_q == RW'(NREG-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fv_q     <= 1'b0;
         lv_q     <= 1'b0;
         line_q   <= '0;
         region_q <= '0;
      end else begin
         fv_q <= in_fv;
         lv_q <= in_lv;
         if (frame_start) begin
            line_q   <= '0;
            region_q <= '0;
         end else if (line_end) begin
            if (!at_last && (line_inc == height_cur)) begin
               line_q   <= '0;
               region_q <= region_q + RW'(1);
            end else begin
               line_q <= line_inc;
            end
         end
      end
   end

   assign region = region_q;

endmodule

// File: rtl/sg_curve_store.sv
module sg_curve_store #(
   parameter int unsigned NREG  = 4,
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 16,
   localparam int unsigned RW   = $clog2(NREG),
   localparam int unsigned BANK_DEPTH = 2 ** (AW + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic [AW-1:0]      rd_idx,
   input  logic               wr_en,
   input  logic [RW-1:0]      wr_region,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   output logic [NREG*DW-1:0] rd_data,
   output logic [NREG-1:0]    bank_sel
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] mem [BANK_DEPTH];
      logic          bank_q;
      logic          dirty_q;
      logic          hit;
      logic [DW-1:0] rd_q;

      assign hit = wr_en && (wr_region == RW'(g));

      // bank pointer: swap at frame start if the shadow was touched
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_q  <= 1'b0;
            dirty_q <= 1'b0;
         end else if (frame_start) begin
            if (dirty_q || hit) begin
               bank_q <= ~bank_q;
            end
            dirty_q <= 1'b0;
         end else if (hit) begin
            dirty_q <= 1'b1;
         end
      end

      // shadow write, active read
      always_ff @(posedge clk) begin
         if (hit) begin
            mem[{~bank_q, wr_addr}] <= wr_data;
         end
         rd_q <= mem[{bank_q, rd_idx}];
      end

      assign rd_data[g*DW +: DW] = rd_q;
      assign bank_sel[g]         = bank_q;
   end

endmodule

// File: rtl/sg_out_fmt.sv
module sg_out_fmt
   import sg_pkg::*;
#(
   parameter int unsigned NREG  = 4,
   parameter int unsigned PIX_W = 12,
   parameter int unsigned DW    = 16,
   parameter int unsigned OUT_W = 16,
   localparam int unsigned RW   = $clog2(NREG),
   localparam int unsigned PAD  = OUT_W - PIX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PIX_W-1:0]   in_pix,
   input  logic               in_lv,
   input  logic               in_fv,
   input  logic [RW-1:0]      region,
   input  logic               fmt_wide,
   input  logic               bypass,
   input  logic [NREG*DW-1:0] rd_data,
   output logic [OUT_W-1:0]   out_pix,
   output logic               out_lv,
   output logic               out_fv,
   output logic [RW-1:0]      out_region
);

   logic             lv_q;
   logic             fv_q;
   logic [RW-1:0]    reg_q;
   logic [PIX_W-1:0] pix_q;
   fmt_e             fmt_q;
   logic             byp_q;
   logic [DW-1:0]    entry;
   logic [OUT_W-1:0] raw_word;
   logic [OUT_W-1:0] conv_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lv_q  <= 1'b0;
         fv_q  <= 1'b0;
         reg_q <= '0;
         pix_q <= '0;
         fmt_q <= FMT_NARROW;
         byp_q <= 1'b0;
      end else begin
         lv_q  <= in_lv;
         fv_q  <= in_fv;
         reg_q <= in_lv ? region : '0;
         pix_q <= in_pix;
         fmt_q <= fmt_wide ? FMT_WIDE : FMT_NARROW;
         byp_q <= bypass;
      end
   end

   assign entry = rd_data[int'(reg_q)*DW +: DW];

   if (PAD > 0) begin : g_pad
      assign raw_word = {pix_q, {PAD{1'b0}}};
   end else begin : g_nopad
      assign raw_word = pix_q;
   end

   always_comb begin
      if (fmt_q == FMT_WIDE) begin
         conv_word = byp_q ? raw_word : OUT_W'(entry);
      end else begin
         conv_word = {{(OUT_W-NARROW_W){1'b0}}, entry[NARROW_W-1:0]};
      end
   end

   assign out_pix    = lv_q ? conv_word : '0;
   assign out_lv     = lv_q;
   assign out_fv     = fv_q;
   assign out_region = reg_q;

endmodule

// File: rtl/subimg_gamma.sv
module subimg_gamma #(
   parameter int unsigned PIX_W  = 12,
   parameter int unsigned NREG   = 4,
   parameter int unsigned LINE_W = 14,
   parameter int unsigned TBL_AW = 8,
   parameter int unsigned OUT_W  = 16,
   localparam int unsigned RW    = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PIX_W-1:0]       in_pix,
   input  logic                   in_lv,
   input  logic                   in_fv,
   input  logic [NREG*LINE_W-1:0] sub_height,
   input  logic                   fmt_wide,
   input  logic                   bypass,
   input  logic                   wr_en,
   input  logic [RW-1:0]          wr_region,
   input  logic [TBL_AW-1:0]      wr_addr,
   input  logic [OUT_W-1:0]       wr_data,
   output logic [OUT_W-1:0]       out_pix,
   output logic                   out_lv,
   output logic                   out_fv,
   output logic [RW-1:0]          out_region
);

   if (NREG < 2) begin : g_bad_nreg
      $error("subimg_gamma: NREG must be at least 2");
   end
   if (TBL_AW > PIX_W) begin : g_bad_aw
      $error("subimg_gamma: TBL_AW must not exceed PIX_W");
   end
   if (OUT_W < PIX_W || OUT_W <= sg_pkg::NARROW_W) begin : g_bad_ow
      $error("subimg_gamma: OUT_W too narrow for bypass or narrow mode");
   end

   logic [RW-1:0]         cur_region;
   logic                  frame_start;
   logic [NREG*OUT_W-1:0] rd_data;
   logic [NREG-1:0]       bank_vec;

   sg_region_track #(
      .NREG   (NREG),
      .LINE_W (LINE_W)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_lv       (in_lv),
      .in_fv       (in_fv),
      .sub_height  (sub_height),
      .region      (cur_region),
      .frame_start (frame_start)
   );

   sg_curve_store #(
      .NREG (NREG),
      .AW   (TBL_AW),
      .DW   (OUT_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .rd_idx      (in_pix[PIX_W-1 -: TBL_AW]),
      .wr_en       (wr_en),
      .wr_region   (wr_region),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .bank_sel    (bank_vec)
   );

   sg_out_fmt #(
      .NREG  (NREG),
      .PIX_W (PIX_W),
      .DW    (OUT_W),
      .OUT_W (OUT_W)
   ) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_pix     (in_pix),
      .in_lv      (in_lv),
      .in_fv      (in_fv),
      .region     (cur_region),
      .fmt_wide   (fmt_wide),
      .bypass     (bypass),
      .rd_data    (rd_data),
      .out_pix    (out_pix),
      .out_lv     (out_lv),
      .out_fv     (out_fv),
      .out_region (out_region)
   );

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
   parameter int unsigned NREG  = 4,
   parameter int unsigned OUT_W = 16,
   localparam int unsigned RW   = $clog2(NREG)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_lv,
   input logic             in_fv,
   input logic             fmt_wide,
   input logic             out_lv,
   input logic             out_fv,
   input logic [OUT_W-1:0] out_pix,
   input logic [RW-1:0]    out_region,
   input logic [RW-1:0]    cur_region,
   input logic             frame_start,
   input logic [NREG-1:0]  bank_vec
);

   // R1: valid levels follow the input one clock later
   a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_lv == $past(in_lv) && out_fv == $past(in_fv)));

   // R7: blanking drives zero
   a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_lv |-> (out_pix == '0));

   // R3: region 0 right after a frame start
   a_r3_fs_region: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cur_region == '0));

   // R5: region only steps up by one or returns to zero
   a_r5_region_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && cur_region != $past(cur_region)) |->
         (cur_region == '0 || cur_region == RW'($past(cur_region) + 1'b1)));

   // R6: banks swap only at a frame start
   a_r6_bank_at_fs: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && bank_vec != $past(bank_vec)) |-> $past(frame_start));

   // R4: narrow output keeps its upper byte clear
   a_r4_narrow_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_lv && !$past(fmt_wide)) |-> (out_pix[OUT_W-1:8] == '0));

   // R10: reported region is the region of the sampled line
   a_r10_region_tag: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_lv) |-> (out_region == $past(cur_region)));

endmodule

bind subimg_gamma sg_checker #(
   .NREG  (NREG),
   .OUT_W (OUT_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_lv       (in_lv),
   .in_fv       (in_fv),
   .fmt_wide    (fmt_wide),
   .out_lv      (out_lv),
   .out_fv      (out_fv),
   .out_pix     (out_pix),
   .out_region  (out_region),
   .cur_region  (cur_region),
   .frame_start (frame_start),
   .bank_vec    (bank_vec)
);

// File: tb/test_subimg_gamma.sv
module test_subimg_gamma;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] in_pix = '0;
   logic        in_lv = 1'b0;
   logic        in_fv = 1'b0;
   logic [55:0] sub_height = '0;
   logic        fmt_wide = 1'b0;
   logic        bypass = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_region = '0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] out_pix;
   logic        out_lv;
   logic        out_fv;
   logic [1:0]  out_region;

   subimg_gamma i_subimg_gamma (
      .clk(clk), .rst_n(rst_n), .in_pix(in_pix), .in_lv(in_lv), .in_fv(in_fv),
      .sub_height(sub_height), .fmt_wide(fmt_wide), .bypass(bypass),
      .wr_en(wr_en), .wr_region(wr_region), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_pix(out_pix), .out_lv(out_lv), .out_fv(out_fv), .out_region(out_region)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   string tag = "R2";

   // bench model
   int    act_gen [4];
   int    pend_gen [4];
   bit    pend [4];
   int    hgt [4];
   int    m_reg = 0;
   int    m_line = 0;
   bit    prev_lv = 0;
   bit    prev_fv = 0;
   bit    m16 = 0;
   bit    mbyp = 0;
   int    w_gen = 0;
   bit    e_valid = 0;
   bit    e_lv, e_fv;
   logic [15:0] e_pix;
   int    e_reg;

   function automatic logic [15:0] curve(int r, int gen, int idx);
      return 16'(((r % 4) << 14) | ((gen % 4) << 12) | 16'h0500 |
                 ((idx ^ (r * 37) ^ (gen * 91)) & 255));
   endfunction

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic set_heights(int h0, int h1, int h2, int h3);
      hgt[0] = h0; hgt[1] = h1; hgt[2] = h2; hgt[3] = h3;
      sub_height = {14'(h3), 14'(h2), 14'(h1), 14'(h0)};
   endtask

   // one clock: check the previous cycle's result, then drive new inputs
   task automatic step(bit lv, bit fv, logic [11:0] pix, bit we, int wr, int wa);
      @(negedge clk);
      if (e_valid) begin
         check("R1", "out_lv", 32'(out_lv), 32'(e_lv));
         check("R1", "out_fv", 32'(out_fv), 32'(e_fv));
         if (e_lv) begin
            check(tag, "out_pix", 32'(out_pix), 32'(e_pix));
            check("R10", "out_region", 32'(out_region), 32'(e_reg));
         end else begin
            check("R7", "blank out_pix", 32'(out_pix), 32'h0);
         end
      end
      in_lv = lv; in_fv = fv; in_pix = pix;
      fmt_wide = m16; bypass = mbyp;
      wr_en = we; wr_region = 2'(wr); wr_addr = 8'(wa);
      wr_data = curve(wr, w_gen, wa);
      if (we) begin
         pend[wr] = 1;
         pend_gen[wr] = w_gen;
      end
      if (fv && !prev_fv) begin
         m_reg = 0; m_line = 0;
         for (int r = 0; r < 4; r++) begin
            if (pend[r]) act_gen[r] = pend_gen[r];
            pend[r] = 0;
         end
      end
      e_lv = lv; e_fv = fv; e_reg = m_reg;
      if (m16) e_pix = mbyp ? {pix, 4'b0000} : curve(m_reg, act_gen[m_reg], int'(pix[11:4]));
      else e_pix = {8'h00, curve(m_reg, act_gen[m_reg], int'(pix[11:4]))[7:0]};
      if (!lv && prev_lv && fv) begin
         if (m_reg != 3 && m_line + 1 == hgt[m_reg]) begin
            m_reg++; m_line = 0;
         end else begin
            m_line++;
         end
      end
      prev_lv = lv; prev_fv = fv; e_valid = 1;
   endtask

   task automatic send_line(int n, int base);
      for (int i = 0; i < n; i++) step(1, 1, 12'((base + i * 293) & 12'hFFF), 0, 0, 0);
      step(0, 1, 12'h0, 0, 0, 0);
      step(0, 1, 12'h0, 0, 0, 0);
   endtask

   task automatic new_frame();
      step(0, 0, 12'h0, 0, 0, 0);
      step(0, 0, 12'h0, 0, 0, 0);
      step(0, 1, 12'h0, 0, 0, 0);
      step(0, 1, 12'h0, 0, 0, 0);
   endtask

   task automatic load_table(int r, int gen, bit fv);
      w_gen = gen;
      for (int a = 0; a < 256; a++) step(0, fv, 12'h0, 1, r, a);
      step(0, fv, 12'h0, 0, 0, 0);
   endtask

   // R9: reset state
   task automatic t_reset();
      @(negedge clk);
      check("R9", "out_lv", 32'(out_lv), 0);
      check("R9", "out_fv", 32'(out_fv), 0);
      check("R9", "out_pix", 32'(out_pix), 0);
      check("R9", "out_region", 32'(out_region), 0);
   endtask

   // R2/R5: regions follow programmed heights, last region holds
   task automatic t_regions();
      for (int r = 0; r < 4; r++) load_table(r, 0, 0);
      m16 = 1; mbyp = 0;
      set_heights(2, 3, 1, 5);
      tag = "R2";
      new_frame();
      tag = "R5";
      for (int l = 0; l < 12; l++) send_line(6, l * 211);
   endtask

   // R3: frame restart in mid-stack returns to region 0
   task automatic t_restart();
      set_heights(1, 1, 1, 1);
      tag = "R3";
      new_frame();
      for (int l = 0; l < 3; l++) send_line(4, l * 97);
      new_frame();
      send_line(4, 1500);
      check("R3", "model region after restart line", 32'(m_reg), 1);
      send_line(4, 1700);
   endtask

   // R5: zero-height region holds
   task automatic t_zero_height();
      set_heights(1, 0, 2, 2);
      tag = "R5";
      new_frame();
      for (int l = 0; l < 5; l++) send_line(5, l * 401 + 7);
   endtask

   // R4/R8: output formats
   task automatic t_formats();
      set_heights(2, 2, 2, 2);
      new_frame();
      tag = "R4"; m16 = 0; mbyp = 1;
      send_line(8, 33);
      tag = "R8"; m16 = 1; mbyp = 1;
      send_line(8, 2049);
      tag = "R8"; m16 = 1; mbyp = 0;
      send_line(8, 3001);
      tag = "R4"; m16 = 0; mbyp = 0;
      send_line(8, 555);
   endtask

   // R6: double-buffered table update
   task automatic t_dbuf();
      set_heights(3, 3, 3, 3);
      m16 = 1; mbyp = 0;
      tag = "R6";
      new_frame();
      send_line(6, 100);
      load_table(0, 1, 1);
      send_line(6, 100);
      check("R6", "model region-0 gen during frame", 32'(act_gen[0]), 0);
      new_frame();
      send_line(6, 100);
      send_line(6, 700);
      send_line(6, 900);
      send_line(6, 100);
      check("R6", "model region-1 gen unchanged", 32'(act_gen[1]), 0);
   endtask

   // R7: blanking cycles with nonzero data
   task automatic t_blank();
      tag = "R7";
      step(0, 1, 12'hFFF, 0, 0, 0);
      step(0, 1, 12'hABC, 0, 0, 0);
      step(0, 0, 12'h123, 0, 0, 0);
      step(0, 0, 12'h000, 0, 0, 0);
   endtask

   initial begin
      for (int r = 0; r < 4; r++) begin
         act_gen[r] = 0; pend_gen[r] = 0; pend[r] = 0; hgt[r] = 0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regions();
      t_restart();
      t_zero_height();
      t_formats();
      t_dbuf();
      t_blank();
      step(0, 0, 12'h0, 0, 0, 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule